// File: doc/BRIEF.md
# Minimum-Transition Vector Sequencer

This block sits between a multilevel space-vector modulator and the leg drivers of a three-phase inverter. Each switching period it receives the three vertices of the active triangle, as oblique (g,h) coordinates and one switching function per vertex, plus a sector code and three dwell counts. It finds the single transition between vertices that would move two legs at once, and then orders the vertices so that this transition is never taken. The leg positions are driven through a mirrored six-segment pattern, and a counter times each segment.

All inputs are sampled together in the clock edge that opens a period. The host sees a one-cycle `period_start` pulse, which is its cue to present the next sample. The sample must then be held until the period closes. If the pairwise test does not find exactly one forbidden move, the block raises `order_fault` and applies the vertices in the order in which they arrived.

Top module: `leg_sequencer`

## Requirements
- R1: While `rst_n` is low, `leg_pos`, `seg_idx`, `period_start` and `order_fault` are all zero. The first period opens in the first clock edge after reset is released.
- R2: Inputs are sampled only in the edge that opens a period. A change to any input during a period has no effect on that period's outputs.
- R3: Sector code 0 uses this rule: a move between two vertices is forbidden when their h coordinates are equal. The forbidden pair x→y is labelled first→last in the application order x, other, y, other, x mirrored (x, other, y, y, other, x).
- R4: Sector code 1 uses this rule: a move is forbidden when g+h is equal for both vertices. The resulting order is the same x, other, y, y, other, x.
- R5: Sector code 2 uses this rule: a move is forbidden when the g coordinates are equal. The resulting order is the same x, other, y, y, other, x.
- R6: Pairs are tested in the order (0,1), (1,2), (2,0), and a pair (i,j) names the move i→j. If the count of forbidden pairs is not exactly one, or if the sector code is 3, then `order_fault` is 1 for the whole period and the vertices are applied in the order 0, 1, 2, 2, 1, 0. Otherwise `order_fault` is 0.
- R7: Segment s (0..5) shows application slot p = s for s<3 and p = 5-s otherwise. It lasts exactly `dwell` field p cycles. A period therefore lasts twice the sum of the three counts.
- R8: A segment whose count is zero is skipped, and `seg_idx` jumps over it. If all three counts are zero, the period lasts one cycle, in segment 0, showing the first vector.
- R9: `period_start` is 1 only in the first cycle of each period. `seg_idx` holds the current segment number, from 0 to 5, and only increases within a period.
- R10: When the sector's vertices share a fixed leg and no fault is flagged, each move within a period leaves at least one leg unchanged.
- R11: `leg_pos` does not change while `seg_idx` holds and no period starts.

Field layout: vertex i has g at `vtx_g[i*CRD_W +: CRD_W]` and h at `vtx_h[i*CRD_W +: CRD_W]`, both in two's complement. Leg j of vertex i is at `vtx_sw[(i*3+j)*LEG_W +: LEG_W]`, where leg 0 is phase A. Count p is at `dwell[p*DUR_W +: DUR_W]`. Leg j of the output is at `leg_pos[j*LEG_W +: LEG_W]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sector | input | 2 | Sector code: 0, 1, 2; 3 is invalid |
| vtx_g | input | 3*CRD_W | g coordinates of the three vertices |
| vtx_h | input | 3*CRD_W | h coordinates of the three vertices |
| vtx_sw | input | 9*LEG_W | Switching function per vertex and leg |
| dwell | input | 3*DUR_W | Dwell counts for application slots 0..2 |
| leg_pos | output | 3*LEG_W | Current position of each leg |
| seg_idx | output | 3 | Current segment, 0..5 |
| period_start | output | 1 | High in the first cycle of a period |
| order_fault | output | 1 | Vertex labelling failed for this period |

## Verification
Some properties are checked by assertions on every cycle. These are: the range of the segment number and its rise within a period; leg positions holding inside a segment; the fault flag changing only at a period boundary; and at least one leg staying put between consecutive cycles of a valid period. The bench scenarios are what show the rest. They show that each sector's difference rule picks the right pair, in every pair position including the wrap-around pair, and that the vertices are ordered and timed by the mirrored counts. They also show that zero counts are skipped, that an all-zero sample collapses to a single cycle, and that samples changed mid-period are ignored.

// File: rtl/leg_sequencer.sv
module leg_sequencer #(
  parameter int LEG_W = 2,
  parameter int CRD_W = 4,
  parameter int DUR_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           sector,
  input  logic [3*CRD_W-1:0]   vtx_g,
  input  logic [3*CRD_W-1:0]   vtx_h,
  input  logic [9*LEG_W-1:0]   vtx_sw,
  input  logic [3*DUR_W-1:0]   dwell,
  output logic [3*LEG_W-1:0]   leg_pos,
  output logic [2:0]           seg_idx,
  output logic                 period_start,
  output logic                 order_fault
);
  localparam int VW = 3*LEG_W;

  function automatic logic [1:0] slot_of(input logic [2:0] s);
    return (s < 3'd3) ? s[1:0] : 2'(3'd5 - s);
  endfunction

  logic [CRD_W-1:0] g [3];
  logic [CRD_W-1:0] h [3];
  logic [CRD_W:0]   gh [3];
  logic [VW-1:0]    v [3];
  logic [DUR_W-1:0] d_in [3];

  for (genvar i = 0; i < 3; i++) begin : g_unpack
    assign g[i]    = vtx_g[i*CRD_W +: CRD_W];
    assign h[i]    = vtx_h[i*CRD_W +: CRD_W];
    assign gh[i]   = {g[i][CRD_W-1], g[i]} + {h[i][CRD_W-1], h[i]};
    assign v[i]    = vtx_sw[i*VW +: VW];
    assign d_in[i] = dwell[i*DUR_W +: DUR_W];
  end

  logic [2:0] forb;
  always_comb begin
    for (int k = 0; k < 3; k++) begin
      case (sector)
        2'd0:    forb[k] = (h[k] == h[(k+1)%3]);
        2'd1:    forb[k] = (gh[k] == gh[(k+1)%3]);
        2'd2:    forb[k] = (g[k] == g[(k+1)%3]);
        default: forb[k] = 1'b0;
      endcase
    end
  end

  logic          lbl_ok;
  logic [VW-1:0] seq_sel [3];
  assign lbl_ok = ($countones(forb) == 1);

  always_comb begin
    case (forb)
      3'b001:  seq_sel = '{v[0], v[2], v[1]};
      3'b010:  seq_sel = '{v[1], v[0], v[2]};
      3'b100:  seq_sel = '{v[2], v[1], v[0]};
      default: seq_sel = '{v[0], v[1], v[2]};
    endcase
  end

  logic [VW-1:0]    seq_q [3];
  logic [DUR_W-1:0] dur_q [3];
  logic [2:0]       seg_q;
  logic [DUR_W-1:0] cnt_q;
  logic             pst_q, flt_q;

  logic       nxt_hit, fst_hit;
  logic [2:0] nxt_seg, fst_seg;
  always_comb begin
    nxt_hit = 1'b0;
    nxt_seg = '0;
    fst_hit = 1'b0;
    fst_seg = '0;
    for (int s = 5; s >= 0; s--) begin
      if (s > int'(seg_q) && dur_q[slot_of(3'(s))] != '0) begin
        nxt_hit = 1'b1;
        nxt_seg = 3'(s);
      end
      if (d_in[slot_of(3'(s))] != '0) begin
        fst_hit = 1'b1;
        fst_seg = 3'(s);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seq_q <= '{default: '0};
      dur_q <= '{default: '0};
      seg_q <= '0;
      cnt_q <= '0;
      pst_q <= 1'b0;
      flt_q <= 1'b0;
    end else begin
      pst_q <= 1'b0;
      if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end else if (nxt_hit) begin
        seg_q <= nxt_seg;
        cnt_q <= dur_q[slot_of(nxt_seg)] - 1'b1;
      end else begin
        seq_q <= seq_sel;
        dur_q <= d_in;
        flt_q <= !lbl_ok;
        pst_q <= 1'b1;
        seg_q <= fst_seg;
        cnt_q <= fst_hit ? d_in[slot_of(fst_seg)] - 1'b1 : '0;
      end
    end
  end

  assign leg_pos      = seq_q[slot_of(seg_q)];
  assign seg_idx      = seg_q;
  assign period_start = pst_q;
  assign order_fault  = flt_q;
endmodule

module leg_sequencer_chk #(
  parameter int LEG_W = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic [3*LEG_W-1:0] leg_pos,
  input logic [2:0]         seg_idx,
  input logic               period_start,
  input logic               order_fault
);
  logic [3*LEG_W-1:0] prev_pos;
  logic [2:0]         chg;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_pos <= '0;
    else        prev_pos <= leg_pos;
  end

  for (genvar j = 0; j < 3; j++) begin : g_chg
    assign chg[j] = (leg_pos[j*LEG_W +: LEG_W] != prev_pos[j*LEG_W +: LEG_W]);
  end

  assert_seg_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    seg_idx <= 3'd5);

  assert_seg_rises_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!period_start && !$stable(seg_idx)) |-> (seg_idx > $past(seg_idx)));

  assert_hold_in_seg_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!period_start && $stable(seg_idx)) |-> $stable(leg_pos));

  assert_fault_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !period_start |-> $stable(order_fault));

  assert_fixed_leg_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!period_start && !order_fault) |-> (chg != 3'b111));
endmodule

bind leg_sequencer leg_sequencer_chk #(.LEG_W(LEG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .leg_pos(leg_pos), .seg_idx(seg_idx),
  .period_start(period_start), .order_fault(order_fault)
);

// File: tb/sim_leg_sequencer.sv
module sim_leg_sequencer;
  localparam int LW = 2;
  localparam int CW = 4;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    sector = '0;
  logic [3*CW-1:0] vtx_g = '0;
  logic [3*CW-1:0] vtx_h = '0;
  logic [9*LW-1:0] vtx_sw = '0;
  logic [3*DW-1:0] dwell = '0;
  logic [3*LW-1:0] leg_pos;
  logic [2:0]    seg_idx;
  logic          period_start, order_fault;

  always #2 clk = ~clk;

  leg_sequencer #(.LEG_W(LW), .CRD_W(CW), .DUR_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .sector(sector), .vtx_g(vtx_g), .vtx_h(vtx_h),
    .vtx_sw(vtx_sw), .dwell(dwell), .leg_pos(leg_pos), .seg_idx(seg_idx),
    .period_start(period_start), .order_fault(order_fault));

  typedef struct {
    logic [2:0]      seg;
    logic [3*LW-1:0] pos;
    logic            pst;
    logic            flt;
    string           tag;
  } item_t;

  item_t q[$];
  int checks = 0;
  int errors = 0;
  int pstarts = 0;
  bit started = 0;

  function automatic logic [3*LW-1:0] sw(input int a, input int b, input int c);
    return {LW'(c), LW'(b), LW'(a)};
  endfunction

  task automatic apply(input int sec,
                       input int g0, input int h0, input logic [3*LW-1:0] s0,
                       input int g1, input int h1, input logic [3*LW-1:0] s1,
                       input int g2, input int h2, input logic [3*LW-1:0] s2,
                       input int d0, input int d1, input int d2);
    sector = 2'(sec);
    vtx_g  = {CW'(g2), CW'(g1), CW'(g0)};
    vtx_h  = {CW'(h2), CW'(h1), CW'(h0)};
    vtx_sw = {s2, s1, s0};
    dwell  = {DW'(d2), DW'(d1), DW'(d0)};
  endtask

  // Expected output per cycle: slot p = s or 5-s, dwell p cycles (R7), zero skipped (R8)
  task automatic expect_period(input logic [3*LW-1:0] a0, input logic [3*LW-1:0] a1,
                               input logic [3*LW-1:0] a2, input int d0, input int d1,
                               input int d2, input bit flt, input string tag);
    logic [3*LW-1:0] vec [3];
    int dur [3];
    bit first;
    vec = '{a0, a1, a2};
    dur = '{d0, d1, d2};
    first = 1;
    if (d0 + d1 + d2 == 0) begin
      q.push_back('{3'd0, a0, 1'b1, flt, tag});
      return;
    end
    for (int s = 0; s < 6; s++) begin
      int p;
      p = (s < 3) ? s : 5 - s;
      for (int c = 0; c < dur[p]; c++) begin
        q.push_back('{3'(s), vec[p], first, flt, tag});
        first = 0;
      end
    end
  endtask

  task automatic set_a(input int d0, input int d1, input int d2);
    apply(0, 1, 0, sw(2,1,1), 0, 1, sw(2,2,1), 1, 1, sw(2,1,0), d0, d1, d2);
  endtask

  task automatic garbage();
    apply(2, 2, 0, sw(2,0,0), 1, 0, sw(2,1,1), 0, 0, sw(2,2,2), 5, 5, 5);
  endtask

  task automatic wait_ps(input int n);
    wait (pstarts >= n);
    #1;
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      checks++;
      if (leg_pos !== '0 || seg_idx !== '0 || period_start !== 1'b0 || order_fault !== 1'b0) begin
        errors++;
        $display("FAIL R1 reset: got pos=%h seg=%0d ps=%b flt=%b, expected all zero",
                 leg_pos, seg_idx, period_start, order_fault);
      end
    end else begin
      if (period_start === 1'b1) begin
        started = 1;
        pstarts++;
      end
      if (started && q.size() > 0) begin
        item_t e;
        e = q.pop_front();
        checks++;
        if (seg_idx !== e.seg || leg_pos !== e.pos || period_start !== e.pst || order_fault !== e.flt) begin
          errors++;
          $display("FAIL %s: got seg=%0d pos=%h ps=%b flt=%b, expected seg=%0d pos=%h ps=%b flt=%b",
                   e.tag, seg_idx, leg_pos, period_start, order_fault, e.seg, e.pos, e.pst, e.flt);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got hung run, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R3: sector 0, forbidden pair (1,2); R1: first period right after reset
    set_a(2, 3, 1);
    expect_period(sw(2,2,1), sw(2,1,1), sw(2,1,0), 2, 3, 1, 0, "R1/R3/R7/R9 sector0");
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R2: mid-period garbage ignored; R4: sector 1, wrap pair (2,0); R8 slot 0 zero
    wait_ps(1);
    garbage();
    repeat (3) @(negedge clk);
    apply(1, -2, 1, sw(0,2,1), -1, 1, sw(1,2,1), -1, 0, sw(1,2,2), 0, 2, 2);
    expect_period(sw(1,2,2), sw(1,2,1), sw(0,2,1), 0, 2, 2, 0, "R2/R4/R8 sector1");

    // R5: sector 2, pair (0,1); R8 slot 1 zero
    wait_ps(2);
    garbage();
    repeat (3) @(negedge clk);
    apply(2, 1, -2, sw(1,0,2), 1, -1, sw(2,1,2), 2, -2, sw(2,0,2), 1, 0, 3);
    expect_period(sw(1,0,2), sw(2,0,2), sw(2,1,2), 1, 0, 3, 0, "R2/R5/R8 sector2");

    // R6: all three pairs forbidden -> fault, input order
    wait_ps(3);
    garbage();
    repeat (3) @(negedge clk);
    apply(0, 2, 0, sw(2,0,0), 1, 0, sw(2,1,1), 0, 0, sw(2,2,2), 1, 1, 1);
    expect_period(sw(2,0,0), sw(2,1,1), sw(2,2,2), 1, 1, 1, 1, "R6 multi-forbidden");

    // R6: sector code 3 -> fault, input order
    wait_ps(4);
    apply(3, 1, 0, sw(2,1,1), 0, 1, sw(2,2,1), 1, 1, sw(2,1,0), 1, 2, 1);
    expect_period(sw(2,1,1), sw(2,2,1), sw(2,1,0), 1, 2, 1, 1, "R6 sector3");

    // R8: all counts zero -> one-cycle period in segment 0
    wait_ps(5);
    set_a(0, 0, 0);
    expect_period(sw(2,2,1), sw(2,1,1), sw(2,1,0), 0, 0, 0, 0, "R8 all-zero");

    // R5/R7/R9: back to back after a one-cycle period; R10, R11 by assertions
    wait_ps(6);
    apply(2, 1, -2, sw(1,0,2), 1, -1, sw(2,1,2), 2, -2, sw(2,0,2), 2, 1, 1);
    expect_period(sw(1,0,2), sw(2,0,2), sw(2,1,2), 2, 1, 1, 0, "R5/R7/R9 final");

    wait (q.size() == 0);
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule